// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of an 8192-bit serial EEPROM that is reached over a three-wire bus. The wires are a chip select, a serial clock and a serial data input, and there is one data output with an output enable. The bus pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer, and the serial clock is edge-detected, so every bus bit is taken on a system clock cycle. A static organization input chooses 1024 byte locations or 512 sixteen-bit words. A static program-enable input is a hardware write inhibit.

One state machine decodes every instruction. The states are `S_IDLE`, `S_OPC`, `S_ADDR`, `S_DATA`, `S_READ` and `S_DONE`, and the transitions are:
- `S_IDLE` to `S_OPC`: a start bit is seen and the part is not busy.
- `S_OPC` to `S_ADDR`: two opcode bits have been taken.
- `S_ADDR` to `S_READ`: the address is complete and the opcode is a read.
- `S_ADDR` to `S_DATA`: the address is complete and the opcode is a write or fill-all.
- `S_ADDR` to `S_DONE`: the address is complete and the opcode is an erase, erase-all, enable or disable.
- `S_DATA` to `S_DONE`: the last data bit has been taken.
- Any state to `S_IDLE`: chip select goes low.

A programming operation changes the array in one cycle. It then starts a program-cycle counter, which models the self-timed write. While the counter runs, the data output reports busy.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the erase/write enable latch is clear, every location reads all ones, and `sdo_oe_o` is low while chip select is low.
- R2: With `org_i`=1 the array holds 512 words of 16 bits and takes 9-bit addresses. With `org_i`=0 it holds 1024 bytes and takes 10-bit addresses. Byte address 2k+1 is the upper half of word k and byte address 2k is the lower half.
- R3: With chip select high, 0 bits on DI are ignored until the first 1, and that first 1 is the start bit.
- R4: The two bits after the start bit are the opcode: 10 READ, 01 WRITE, 11 ERASE. Opcode 00 takes the top two address bits as a sub-code: 11 EWEN, 10 ERAL, 01 WRAL, 00 EWDS. Address and data bits are sent MSB first.
- R5: READ drives a 0 bit after the rising edge of the last address bit. The location's bits then follow MSB first, one per rising edge.
- R6: If clocking continues with chip select high, the next address is streamed without a dummy bit. The address wraps from the last location to 0.
- R7: WRITE, when allowed, stores the data bits at the address.
- R8: ERASE, when allowed, sets every bit of the addressed location to 1.
- R9: ERAL sets the whole array to ones. WRAL writes its data into every location; in byte mode this fills both halves of every word.
- R10: EWEN sets the enable latch and EWDS clears it. While the latch is clear, WRITE, ERASE, ERAL and WRAL leave the array unchanged and do not start a busy period.
- R11: While `pe_i` is low, programming operations leave the array unchanged and do not start a busy period, whatever the state of the latch.
- R12: After an accepted programming operation with chip select high, DO reads 0 for PROG_CYCLES system clocks and then 1. Start bits that arrive while busy are ignored, so the whole instruction is dropped.
- R13: Chip select low disables the output and aborts a partly received instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset (power-on) |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| org_i | input | 1 | Organization: 1 = 16-bit words, 0 = bytes |
| pe_i | input | 1 | Program enable; low blocks all writes and erases |
| sdo_o | output | 1 | Serial data out: read data or ready (1) / busy (0) |
| sdo_oe_o | output | 1 | Output enable for sdo_o |

## Verification
Two functions can meet on the same edge. The first is the busy timer, which is still counting down. The second is the start-bit detector, which sees a new instruction. The bench makes this happen by sending a full WRITE inside the busy window left by an earlier WRITE. It then judges the result at the ports: DO is low straight after the first WRITE and goes high only after the window. The target of the second WRITE still reads all ones. Blocked operations, whether by the latch or by the program-enable pin, are judged the same way: DO stays high right after the instruction, and the array is unchanged.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPC,
        S_ADDR,
        S_DATA,
        S_READ,
        S_DONE
    } mw_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WRITE,
        OP_ERASE,
        OP_ERAL,
        OP_WRAL
    } mw_op_e;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] SUB_EWDS = 2'b00;
    localparam logic [1:0] SUB_WRAL = 2'b01;
    localparam logic [1:0] SUB_ERAL = 2'b10;
    localparam logic [1:0] SUB_EWEN = 2'b11;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int N        = 3,
    parameter int EDGE_IDX = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o,
    output logic         rise_o
);
    logic prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [1:0] sh;
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[0], d_i[g]};
        end
        assign q_o[g] = sh[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= q_o[EDGE_IDX];
    end

    assign rise_o = q_o[EDGE_IDX] & ~prev_q;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic busy_o
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (go_i)       cnt <= CW'(PROG_CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy_o = (cnt != '0);

    // R12: a program cycle is never restarted while one is running
    a_r12_go_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !busy_o);
    // R12: counter never exceeds its load value
    a_r12_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(PROG_CYCLES));
endmodule

// File: rtl/mw_array.sv
module mw_array
    import mw_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              org_i,
    input  mw_op_e            op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2*BYTE_W-1:0] data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [2*BYTE_W-1:0] rd_lj_o
);
    localparam int WW    = 2 * BYTE_W;
    localparam int IW    = ADDR_W - 1;
    localparam int DEPTH = 2 ** IW;

    logic [WW-1:0] mem [DEPTH];
    logic [IW-1:0] wi, ri;
    logic          whi, rhi;

    assign wi  = org_i ? addr_i[IW-1:0] : addr_i[ADDR_W-1:1];
    assign whi = addr_i[0];
    assign ri  = org_i ? rd_addr_i[IW-1:0] : rd_addr_i[ADDR_W-1:1];
    assign rhi = rd_addr_i[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else begin
            case (op_i)
                OP_WRITE: begin
                    if (org_i)    mem[wi] <= data_i;
                    else if (whi) mem[wi][WW-1:BYTE_W] <= data_i[BYTE_W-1:0];
                    else          mem[wi][BYTE_W-1:0]  <= data_i[BYTE_W-1:0];
                end
                OP_ERASE: begin
                    if (org_i)    mem[wi] <= '1;
                    else if (whi) mem[wi][WW-1:BYTE_W] <= '1;
                    else          mem[wi][BYTE_W-1:0]  <= '1;
                end
                OP_ERAL: begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
                end
                OP_WRAL: begin
                    for (int i = 0; i < DEPTH; i++)
                        mem[i] <= org_i ? data_i : {2{data_i[BYTE_W-1:0]}};
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        if (org_i)    rd_lj_o = mem[ri];
        else if (rhi) rd_lj_o = {mem[ri][WW-1:BYTE_W], {BYTE_W{1'b0}}};
        else          rd_lj_o = {mem[ri][BYTE_W-1:0], {BYTE_W{1'b0}}};
    end
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int BYTE_W      = 8,
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic sdi_i,
    input  logic org_i,
    input  logic pe_i,
    output logic sdo_o,
    output logic sdo_oe_o
);
    localparam int WW    = 2 * BYTE_W;
    localparam int CMAX  = (WW > ADDR_W) ? WW : ADDR_W;
    localparam int CNT_W = $clog2(CMAX + 1);

    mw_state_e state, state_n;
    mw_op_e    req_op, arr_op;

    logic [2:0]        sync_q;
    logic              cs_s, di_s, sck_rise, busy, prog_go;
    logic [1:0]        opc, sub;
    logic [ADDR_W-1:0] addr_q, addr_full, addr_inc, rd_addr, arr_addr;
    logic [WW-2:0]     data_q;
    logic [WW-1:0]     data_full, rd_sr, rd_lj;
    logic [CNT_W-1:0]  cnt, aw_m1, dw_m1, dw_full;
    logic              out_bit, wen_q;

    mw_sync #(.N(3), .EDGE_IDX(1)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    ({cs_i, sclk_i, sdi_i}),
        .q_o    (sync_q),
        .rise_o (sck_rise)
    );
    assign cs_s = sync_q[2];
    assign di_s = sync_q[0];

    mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (prog_go),
        .busy_o (busy)
    );

    // field lengths follow the organization
    assign aw_m1   = org_i ? CNT_W'(ADDR_W - 2) : CNT_W'(ADDR_W - 1);
    assign dw_full = org_i ? CNT_W'(WW) : CNT_W'(BYTE_W);
    assign dw_m1   = dw_full - 1'b1;

    assign addr_full = {addr_q[ADDR_W-2:0], di_s};
    assign data_full = {data_q, di_s};
    assign sub       = org_i ? addr_full[ADDR_W-2:ADDR_W-3] : addr_full[ADDR_W-1:ADDR_W-2];
    assign addr_inc  = org_i ? {1'b0, addr_q[ADDR_W-2:0] + 1'b1} : addr_q + 1'b1;
    assign rd_addr   = (state == S_ADDR) ? addr_full : addr_inc;
    assign arr_addr  = (state == S_ADDR) ? addr_full : addr_q;

    assign prog_go = (req_op != OP_NONE) && wen_q && pe_i;
    assign arr_op  = prog_go ? req_op : OP_NONE;

    mw_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .org_i     (org_i),
        .op_i      (arr_op),
        .addr_i    (arr_addr),
        .data_i    (data_full),
        .rd_addr_i (rd_addr),
        .rd_lj_o   (rd_lj)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // next state and programming request
    always_comb begin
        state_n = state;
        req_op  = OP_NONE;
        if (!cs_s) begin
            state_n = S_IDLE;
        end else if (sck_rise) begin
            unique case (state)
                S_IDLE: if (di_s && !busy) state_n = S_OPC;
                S_OPC:  if (cnt == CNT_W'(1)) state_n = S_ADDR;
                S_ADDR: begin
                    if (cnt == aw_m1) begin
                        case (opc)
                            OPC_READ:  state_n = S_READ;
                            OPC_WRITE: state_n = S_DATA;
                            OPC_ERASE: begin
                                req_op  = OP_ERASE;
                                state_n = S_DONE;
                            end
                            default: begin
                                if (sub == SUB_WRAL) begin
                                    state_n = S_DATA;
                                end else begin
                                    if (sub == SUB_ERAL) req_op = OP_ERAL;
                                    state_n = S_DONE;
                                end
                            end
                        endcase
                    end
                end
                S_DATA: begin
                    if (cnt == dw_m1) begin
                        req_op  = (opc == OPC_WRITE) ? OP_WRITE : OP_WRAL;
                        state_n = S_DONE;
                    end
                end
                S_READ: ;
                S_DONE: ;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opc     <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            cnt     <= '0;
            rd_sr   <= '0;
            out_bit <= 1'b0;
            wen_q   <= 1'b0;
        end else if (!cs_s) begin
            cnt <= '0;
        end else if (sck_rise) begin
            unique case (state)
                S_IDLE: begin
                    cnt <= '0;
                    opc <= '0;
                end
                S_OPC: begin
                    opc    <= {opc[0], di_s};
                    addr_q <= '0;
                    cnt    <= (cnt == CNT_W'(1)) ? '0 : cnt + 1'b1;
                end
                S_ADDR: begin
                    addr_q <= addr_full;
                    cnt    <= cnt + 1'b1;
                    if (cnt == aw_m1) begin
                        cnt    <= '0;
                        data_q <= '0;
                        if (opc == OPC_READ) begin
                            rd_sr   <= rd_lj;
                            out_bit <= 1'b0;
                        end
                        if (opc == OPC_EXT && sub == SUB_EWEN) wen_q <= 1'b1;
                        if (opc == OPC_EXT && sub == SUB_EWDS) wen_q <= 1'b0;
                    end
                end
                S_DATA: begin
                    data_q <= data_full[WW-2:0];
                    cnt    <= cnt + 1'b1;
                end
                S_READ: begin
                    if (cnt == dw_full) begin
                        addr_q  <= addr_inc;
                        out_bit <= rd_lj[WW-1];
                        rd_sr   <= rd_lj << 1;
                        cnt     <= CNT_W'(1);
                    end else begin
                        out_bit <= rd_sr[WW-1];
                        rd_sr   <= rd_sr << 1;
                        cnt     <= cnt + 1'b1;
                    end
                end
                S_DONE: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sdo_oe_o = cs_s;
        sdo_o    = (state == S_READ) ? out_bit : !busy;
    end

    // R13: chip select low returns the decoder to idle
    a_r13_idle_after_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> (state == S_IDLE));
    // R5: first bit shown on entering the read phase is the dummy 0
    a_r5_dummy_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ && $past(state) != S_READ) |-> !sdo_o);
    // R6: bit counter of the read stream stays within one location
    a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ) |-> (cnt <= dw_full));
    // R10 / R11: a busy period begins only when latch and pin both allowed it
    a_r10_busy_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen_q && pe_i));
endmodule

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;
    localparam int PROG = 500;
    localparam int H    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sclk = 1'b0, di = 1'b0, org = 1'b1, pe = 1'b1;
    logic sdo, sdo_oe;
    logic last_do;
    int   nchk = 0, nerr = 0;

    always #5 clk = ~clk;

    mw_eeprom #(.ADDR_W(10), .BYTE_W(8), .PROG_CYCLES(PROG)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_i     (cs),
        .sclk_i   (sclk),
        .sdi_i    (di),
        .org_i    (org),
        .pe_i     (pe),
        .sdo_o    (sdo),
        .sdo_oe_o (sdo_oe)
    );

    // rows: {org, address, data}; write then read back
    localparam logic [26:0] VEC [6] = '{
        {1'b1, 10'h000, 16'hA55A},
        {1'b1, 10'h1FF, 16'h1234},
        {1'b0, 10'h005, 16'h003C},
        {1'b0, 10'h3FD, 16'h00C3},
        {1'b1, 10'h0A0, 16'h0001},
        {1'b0, 10'h141, 16'h0080}
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int awid();
        return org ? 9 : 10;
    endfunction

    function automatic int dwid();
        return org ? 16 : 8;
    endfunction

    task automatic bitx(input logic b);
        sclk = 1'b0;
        di   = b;
        wait_cyc(H);
        sclk = 1'b1;
        wait_cyc(H);
        last_do = sdo;
    endtask

    task automatic sendv(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) bitx(v[i]);
    endtask

    task automatic begin_cmd(input int zeros, input logic [1:0] op, input logic [9:0] a);
        cs   = 1'b1;
        sclk = 1'b0;
        wait_cyc(H);
        for (int i = 0; i < zeros; i++) bitx(1'b0);
        bitx(1'b1);
        sendv(16'(op), 2);
        sendv(16'(a), awid());
    endtask

    task automatic end_cmd();
        sclk = 1'b0;
        di   = 1'b0;
        wait_cyc(H);
        cs = 1'b0;
        wait_cyc(H);
    endtask

    task automatic prog(input logic [1:0] op, input logic [9:0] a,
                        input logic [15:0] d, input logic has_data);
        begin_cmd(0, op, a);
        if (has_data) sendv(d, dwid());
        end_cmd();
        wait_cyc(PROG + 20);
    endtask

    task automatic rd(input int zeros, input logic [9:0] a, output logic dummy,
                      output logic [15:0] w0, output logic [15:0] w1);
        logic [15:0] v;
        begin_cmd(zeros, 2'b10, a);
        dummy = last_do;
        w0 = '0;
        w1 = '0;
        for (int k = 0; k < 2; k++) begin
            v = '0;
            for (int i = 0; i < dwid(); i++) begin
                bitx(1'b0);
                v = {v[14:0], last_do};
            end
            if (k == 0) w0 = v; else w1 = v;
        end
        end_cmd();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic        dm;
        logic [15:0] w0, w1, exp;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);

        // R1 / R13: output disabled while chip select low, array erased
        chk("R1 oe low after reset", 16'(sdo_oe), 16'h0);
        org = 1'b1;
        rd(0, 10'h003, dm, w0, w1);
        chk("R1 erased after reset", w0, 16'hFFFF);

        // R10: latch is clear after reset, so WRITE neither changes nor goes busy
        begin_cmd(0, 2'b01, 10'h003);
        sendv(16'h0000, 16);
        wait_cyc(4);
        chk("R10 no busy while latch clear", 16'(sdo), 16'h1);
        end_cmd();
        rd(0, 10'h003, dm, w0, w1);
        chk("R10 locked write ignored", w0, 16'hFFFF);

        // R4: EWEN is sub-code 11 in the top address bits
        prog(2'b00, 10'h180, 16'h0, 1'b0);

        // R7 / R2: table of writes and read-backs in both organizations
        for (int i = 0; i < 6; i++) begin
            org = VEC[i][26];
            prog(2'b01, VEC[i][25:16], VEC[i][15:0], 1'b1);
            rd(0, VEC[i][25:16], dm, w0, w1);
            exp = org ? VEC[i][15:0] : {8'h00, VEC[i][7:0]};
            chk("R7 write read-back", w0, exp);
        end

        // R2: byte halves map onto word halves
        org = 1'b1;
        rd(0, 10'h0A0, dm, w0, w1);
        chk("R2 word built from byte write", w0, 16'h8001);
        org = 1'b0;
        rd(0, 10'h140, dm, w0, w1);
        chk("R2 lower byte of word", w0, 16'h0001);

        // R5 / R6: dummy bit then stream past the last word back to 0
        org = 1'b1;
        rd(0, 10'h1FF, dm, w0, w1);
        chk("R5 dummy bit", 16'(dm), 16'h0);
        chk("R5 first word MSB first", w0, 16'h1234);
        chk("R6 wrap to address 0", w1, 16'hA55A);

        // R8: ERASE word 0
        prog(2'b11, 10'h000, 16'h0, 1'b0);
        rd(0, 10'h000, dm, w0, w1);
        chk("R8 erase sets ones", w0, 16'hFFFF);

        // R12: busy after accepted write; a full WRITE inside the window is dropped
        begin_cmd(0, 2'b01, 10'h010);
        sendv(16'h5555, 16);
        wait_cyc(4);
        chk("R12 busy low", 16'(sdo), 16'h0);
        end_cmd();
        begin_cmd(0, 2'b01, 10'h011);
        sendv(16'h0000, 16);
        end_cmd();
        wait_cyc(PROG);
        cs = 1'b1;
        wait_cyc(H);
        chk("R12 ready high", 16'(sdo), 16'h1);
        cs = 1'b0;
        wait_cyc(H);
        rd(0, 10'h010, dm, w0, w1);
        chk("R12 first write stored", w0, 16'h5555);
        rd(0, 10'h011, dm, w0, w1);
        chk("R12 write during busy ignored", w0, 16'hFFFF);

        // R11: program-enable low blocks writes
        pe = 1'b0;
        begin_cmd(0, 2'b01, 10'h011);
        sendv(16'h0000, 16);
        wait_cyc(4);
        chk("R11 no busy with pe low", 16'(sdo), 16'h1);
        end_cmd();
        pe = 1'b1;
        rd(0, 10'h011, dm, w0, w1);
        chk("R11 array unchanged", w0, 16'hFFFF);

        // R13: abort mid-instruction; output disabled
        cs = 1'b1;
        wait_cyc(H);
        bitx(1'b1);
        sendv(16'h1, 2);
        sendv(16'h0, 4);
        end_cmd();
        chk("R13 oe low with cs low", 16'(sdo_oe), 16'h0);
        // R3: leading zeros before start bit
        rd(3, 10'h011, dm, w0, w1);
        chk("R3 leading zeros ignored / R13 abort left word", w0, 16'hFFFF);
        rd(3, 10'h010, dm, w0, w1);
        chk("R3 read after leading zeros", w0, 16'h5555);

        // R9: WRAL in byte mode, then ERAL
        org = 1'b0;
        prog(2'b00, 10'h100, 16'h005A, 1'b1);
        rd(0, 10'h000, dm, w0, w1);
        chk("R9 wral byte 0", w0, 16'h005A);
        rd(0, 10'h3FF, dm, w0, w1);
        chk("R9 wral last byte", w0, 16'h005A);
        org = 1'b1;
        rd(0, 10'h100, dm, w0, w1);
        chk("R9 wral fills both halves", w0, 16'h5A5A);
        prog(2'b00, 10'h100, 16'h0, 1'b0);
        rd(0, 10'h007, dm, w0, w1);
        chk("R9 eral sets ones", w0, 16'hFFFF);

        // R10: EWDS clears the latch
        prog(2'b00, 10'h000, 16'h0, 1'b0);
        prog(2'b01, 10'h007, 16'h1234, 1'b1);
        rd(0, 10'h007, dm, w0, w1);
        chk("R10 write after EWDS ignored", w0, 16'hFFFF);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule